// File: doc/BRIEF.md
# Byte-Mapped SPI Master Port

This block is an SPI master that a host drives through a small byte-wide register window. A control byte picks one of several slave chip-selects and sets the frame length (8 or 16 bits), the SCLK idle level, which SCLK edge is the sampling edge, and whether chip-select is handled automatically or held by software. A configuration byte picks the SCLK rate, the bit order and an end-of-transfer interrupt enable. The same byte also reports a busy flag. A set of data bytes holds the outgoing frame. The last data byte is special: a write to it both stores the low byte and starts the transfer.

SCLK comes from the system clock through a divider. Each half SCLK period lasts H system cycles, where H = CLK_HZ / (2 x rate). The bytes received on MISO are written back over the frame bytes when the transfer ends, so the host reads its result from the same addresses it wrote. Each transfer has three phases: a lead of one half period with chip-select asserted and SCLK idle, then 2N SCLK toggles, then a trail of one half period before chip-select is released.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, every register reads 0, busy is 0, all csN lines are high, SCLK is low and irq is low.
- R2: The registers sit at these addresses: control at 0, configuration at 1, data bytes 0..3 at 4..7. While idle, a written control byte or data byte reads back unchanged. The control byte fields are: bits 2:0 slave index, bit 3 idle level, bit 4 falling-edge sampling, bit 5 automatic chip-select, bit 6 16-bit frame, bit 7 manual chip-select level.
- R3: A write to address 7 while idle sets busy on the next clock. Busy stays high for exactly H*(2N+1) cycles, where N is 16 or 8. The rate codes in configuration bits 1:0 are: 0 = base rate (2 MHz), 1 = 2x base, 2 = 4x base, and 3 behaves like 0.
- R4: While idle, SCLK sits at control bit 3. During a transfer it toggles exactly 2N times. The first toggle comes H cycles after busy rises, and the toggles are spaced H cycles apart.
- R5: The frame sent on MOSI is {data byte 2, data byte 3} for a 16-bit frame, or data byte 3 alone for an 8-bit frame. It is sent MSB first when configuration bit 3 is 1, otherwise LSB first. MOSI is stable at every sampling edge. The sampling edge is rising when control bit 4 is 0 and falling when it is 1.
- R6: MISO is sampled on each sampling edge, in the same bit order as MOSI. At the end of a 16-bit frame the received word replaces data bytes 2 (high) and 3 (low). At the end of an 8-bit frame it replaces data byte 3 only, and data byte 2 keeps its value.
- R7: With automatic chip-select, csN[index] is low exactly while busy is high, and every other csN line stays high. This gives H cycles of chip-select before the first SCLK edge and H cycles after the last.
- R8: With automatic chip-select off, csN[index] is low exactly when control bit 7 is 1, whether or not a transfer is running.
- R9: A slave index at or above NUM_SLAVES asserts no csN line.
- R10: While busy, writes to every register are ignored, including address 7. Such a write starts no second transfer and does not stop data byte 3 from being written back.
- R11: When configuration bit 2 is 1, irq pulses high for one cycle: the first cycle in which busy reads 0 after a transfer. When the bit is 0, irq stays low.
- R12: Address 1 reads {busy, 3'b000, configuration bits 3:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| addr | input | ADDR_W | Register address for both read and write |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Register read data, combinational from addr |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| csN | output | NUM_SLAVES | Active-low slave selects |
| irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume three things about the inputs. The host holds addr and wrData steady while wrEn is high. CLK_HZ is a multiple of eight times the base rate, so every divider half period is a whole number of cycles of at least one. The slave index selects a real line when a one-hot check is expected. The bench keeps within these limits: it drives every write for one full cycle from a falling clock edge and uses the default 16 MHz clock. It also changes MISO only after a sampling edge, as a well-behaved slave would, across a sweep of every idle level, sampling edge, bit order, frame length and rate code.

// File: rtl/spi_byte_port_pkg.sv
package spi_byte_port_pkg;

  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int CTRL_ADDR = 0;
  localparam int CFG_ADDR  = 1;
  localparam int DATA_BASE = 4;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic       manualCs;
    logic       frame16;
    logic       autoCs;
    logic       fallActive;
    logic       idleHigh;
    logic [2:0] sel;
  } ctrlReg_t;

  // configuration nibble, bit 3 down to bit 0
  typedef struct packed {
    logic       msbFirst;
    logic       irqEn;
    logic [1:0] rate;
  } cfgReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic toggle;
    logic sample;
    logic shiftOut;
    logic finish;
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } spiState_t;

endpackage

// File: rtl/spi_byte_port_ctrl.sv
module spi_byte_port_ctrl
  import spi_byte_port_pkg::*;
#(
  parameter int CLK_HZ       = 16_000_000,
  parameter int SCLK_BASE_HZ = 2_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  logic [1:0] rate,
  input  logic       frame16,
  input  logic       fallActive,
  input  logic       sclkNow,
  output logic       busy,
  output spiStrobe_t strobe
);

  localparam int HALF_SLOW = CLK_HZ / (2 * SCLK_BASE_HZ);
  localparam int HALF_MID  = CLK_HZ / (4 * SCLK_BASE_HZ);
  localparam int HALF_FAST = CLK_HZ / (8 * SCLK_BASE_HZ);
  localparam int DIV_W     = $clog2(HALF_SLOW + 1);
  localparam int EDGE_W    = $clog2(2 * WORD_W);
  localparam int CNT_W     = $clog2(WORD_W + 1);

  spiState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfLen;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] lastEdge;
  logic [CNT_W-1:0]  sampleCnt;
  logic [CNT_W-1:0]  frameBits;
  logic              tick;
  logic              running;

  always_comb begin
    case (rate)
      2'd1:    halfLen = DIV_W'(HALF_MID);
      2'd2:    halfLen = DIV_W'(HALF_FAST);
      default: halfLen = DIV_W'(HALF_SLOW);
    endcase
  end

  assign frameBits = frame16 ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
  assign lastEdge  = frame16 ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * BYTE_W - 1);
  assign tick      = (divCnt == halfLen - DIV_W'(1));
  assign running   = (state == ST_LEAD) || (state == ST_SHIFT);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.start = (state == ST_IDLE) && trigger;
    if (running && tick) begin
      strobe.toggle = 1'b1;
      // the edge leaves sclk at !sclkNow; it samples when that is the active level
      if (sclkNow == fallActive) begin
        strobe.sample = 1'b1;
      end else if ((sampleCnt != '0) && (sampleCnt < frameBits)) begin
        strobe.shiftOut = 1'b1;
      end
    end
    strobe.finish = (state == ST_TRAIL) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      edgeCnt   <= '0;
      sampleCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            state     <= ST_LEAD;
            divCnt    <= '0;
            edgeCnt   <= '0;
            sampleCnt <= '0;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (tick) begin
            divCnt  <= '0;
            edgeCnt <= edgeCnt + EDGE_W'(1);
            if (strobe.sample) sampleCnt <= sampleCnt + CNT_W'(1);
            state <= (edgeCnt == lastEdge) ? ST_TRAIL : ST_SHIFT;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            divCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_byte_port_dp.sv
module spi_byte_port_dp
  import spi_byte_port_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int NUM_DATA   = 4,
  parameter int ADDR_W     = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BYTE_W-1:0]     wrData,
  output logic [BYTE_W-1:0]     rdData,
  input  logic                  busy,
  input  spiStrobe_t            strobe,
  input  logic                  miso,
  output ctrlReg_t              ctrlQ,
  output cfgReg_t               cfgQ,
  output logic                  trigger,
  output logic                  sclkNow,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] csN,
  output logic                  irq
);

  localparam int HI_IDX    = NUM_DATA - 2;
  localparam int LO_IDX    = NUM_DATA - 1;
  localparam int TRIG_ADDR = DATA_BASE + LO_IDX;

  logic [BYTE_W-1:0] dataQ [NUM_DATA];
  logic [WORD_W-1:0] txQ;
  logic [WORD_W-1:0] rxQ;
  logic [WORD_W-1:0] txLoad;
  logic [BYTE_W-1:0] rxLo;
  logic              sclkQ;
  logic              hostWr;
  logic              csActive;

  assign hostWr  = wrEn && !busy;
  assign trigger = hostWr && (addr == ADDR_W'(TRIG_ADDR));

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      cfgQ  <= '0;
    end else if (hostWr) begin
      if (addr == ADDR_W'(CTRL_ADDR)) ctrlQ <= ctrlReg_t'(wrData);
      if (addr == ADDR_W'(CFG_ADDR))  cfgQ  <= cfgReg_t'(wrData[3:0]);
    end
  end

  // the low frame byte sits in the high half of rxQ after an 8-bit LSB-first frame
  assign rxLo = (ctrlQ.frame16 || cfgQ.msbFirst) ? rxQ[BYTE_W-1:0] : rxQ[WORD_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DATA; i++) dataQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (hostWr && (addr == ADDR_W'(DATA_BASE + i))) begin
          dataQ[i] <= wrData;
        end else if (strobe.finish) begin
          if (i == LO_IDX) dataQ[i] <= rxLo;
          else if ((i == HI_IDX) && ctrlQ.frame16) dataQ[i] <= rxQ[WORD_W-1:BYTE_W];
        end
      end
    end
  end

  // frame image, aligned so that the first bit sits at the end mosi reads
  always_comb begin
    if (ctrlQ.frame16)      txLoad = {dataQ[HI_IDX], wrData};
    else if (cfgQ.msbFirst) txLoad = {wrData, {BYTE_W{1'b0}}};
    else                    txLoad = {{BYTE_W{1'b0}}, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ   <= '0;
      rxQ   <= '0;
      sclkQ <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= strobe.finish && cfgQ.irqEn;
      if (strobe.start) begin
        txQ   <= txLoad;
        sclkQ <= ctrlQ.idleHigh;
      end else begin
        if (strobe.toggle) sclkQ <= !sclkQ;
        if (strobe.shiftOut) begin
          txQ <= cfgQ.msbFirst ? {txQ[WORD_W-2:0], 1'b0} : {1'b0, txQ[WORD_W-1:1]};
        end
        if (strobe.sample) begin
          rxQ <= cfgQ.msbFirst ? {rxQ[WORD_W-2:0], miso} : {miso, rxQ[WORD_W-1:1]};
        end
      end
    end
  end

  assign sclkNow = sclkQ;
  assign sclk    = busy ? sclkQ : ctrlQ.idleHigh;
  assign mosi    = cfgQ.msbFirst ? txQ[WORD_W-1] : txQ[0];

  // chip-select decode
  assign csActive = ctrlQ.autoCs ? busy : ctrlQ.manualCs;

  for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_cs
    assign csN[g] = !(csActive && (ctrlQ.sel == 3'(g)));
  end

  // register read mux
  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) rdData = ctrlQ;
    if (addr == ADDR_W'(CFG_ADDR))  rdData = {busy, 3'b000, cfgQ};
    for (int i = 0; i < NUM_DATA; i++) begin
      if (addr == ADDR_W'(DATA_BASE + i)) rdData = dataQ[i];
    end
  end

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_byte_port_pkg::*;
#(
  parameter int CLK_HZ       = 16_000_000,
  parameter int SCLK_BASE_HZ = 2_000_000,
  parameter int NUM_SLAVES   = 4,
  parameter int NUM_DATA     = 4,
  parameter int ADDR_W       = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] csN,
  output logic                  irq
);

  spiStrobe_t strobe;
  ctrlReg_t   ctrlQ;
  cfgReg_t    cfgQ;
  logic       busy;
  logic       trigger;
  logic       sclkNow;

  spi_byte_port_ctrl #(
    .CLK_HZ      (CLK_HZ),
    .SCLK_BASE_HZ(SCLK_BASE_HZ)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigger   (trigger),
    .rate      (cfgQ.rate),
    .frame16   (ctrlQ.frame16),
    .fallActive(ctrlQ.fallActive),
    .sclkNow   (sclkNow),
    .busy      (busy),
    .strobe    (strobe)
  );

  spi_byte_port_dp #(
    .NUM_SLAVES(NUM_SLAVES),
    .NUM_DATA  (NUM_DATA),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .busy   (busy),
    .strobe (strobe),
    .miso   (miso),
    .ctrlQ  (ctrlQ),
    .cfgQ   (cfgQ),
    .trigger(trigger),
    .sclkNow(sclkNow),
    .sclk   (sclk),
    .mosi   (mosi),
    .csN    (csN),
    .irq    (irq)
  );

endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk #(
  parameter int NUM_SLAVES = 4,
  parameter int ADDR_W     = 3,
  parameter int TRIG_ADDR  = 7,
  parameter int CTRL_ADDR  = 0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     addr,
  input logic                  busy,
  input logic                  sclk,
  input logic [NUM_SLAVES-1:0] csN,
  input logic                  irq,
  input logic [7:0]            ctrlByte
);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && addr == ADDR_W'(TRIG_ADDR)) |=> busy);

  // R10
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && addr == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrlByte));

  // R4
  lead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $stable(sclk));

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlByte[5] && (int'(ctrlByte[2:0]) < NUM_SLAVES)) |-> ($countones(~csN) == 1));

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $fell(busy));

endmodule

bind spi_byte_port spi_byte_port_chk #(
  .NUM_SLAVES(NUM_SLAVES),
  .ADDR_W    (ADDR_W),
  .TRIG_ADDR (spi_byte_port_pkg::DATA_BASE + NUM_DATA - 1),
  .CTRL_ADDR (spi_byte_port_pkg::CTRL_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .busy    (busy),
  .sclk    (sclk),
  .csN     (csN),
  .irq     (irq),
  .ctrlByte(ctrlQ)
);

// File: tb/test_spi_byte_port.sv
module test_spi_byte_port;

  localparam int CLK_PERIOD = 10;
  localparam int NSL        = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [2:0]     addr = '0;
  logic [7:0]     wrData = '0;
  logic [7:0]     rdData;
  logic           miso = 1'b0;
  logic           sclk;
  logic           mosi;
  logic [NSL-1:0] csN;
  logic           irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_byte_port i_spi_byte_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    int n = 0;
    s = 8'h80;
    while (s[7] && n < 1000) begin
      hostRead(3'd1, s);
      n++;
    end
  endtask

  function automatic int halfOf(input logic [1:0] r);
    return (r == 2'd1) ? 2 : (r == 2'd2) ? 1 : 4;
  endfunction

  // one automatic-select transfer, with a behavioural slave driving MISO
  task automatic runXfer(input bit idleHigh, input bit fallAct, input bit msb, input bit irqEn,
                         input bit f16, input logic [1:0] rate, input logic [2:0] sel,
                         input logic [15:0] txWord, input logic [15:0] slaveWord);
    int n = f16 ? 16 : 8;
    int h = halfOf(rate);
    int k = 1, j = 0, busyCnt = 0, edges = 0, firstEdge = 0, lastEdge = 0;
    int irqCnt = 0, csBad = 0;
    bit done = 0;
    logic prevSclk;
    logic [15:0] got = '0;
    logic [15:0] expTx;
    logic [NSL-1:0] expCs;
    logic [7:0] rd;
    expCs = ~(NSL'(1) << sel);
    expTx = f16 ? txWord : {8'h00, txWord[7:0]};
    hostWrite(3'd0, {1'b0, f16, 1'b1, fallAct, idleHigh, sel});
    hostWrite(3'd1, {4'b0000, msb, irqEn, rate});
    hostWrite(3'd6, txWord[15:8]);
    miso = msb ? slaveWord[n-1] : slaveWord[0];
    #1 check("R4", "idle sclk level", 32'(sclk), 32'(idleHigh));
    hostWrite(3'd7, txWord[7:0]);
    prevSclk = idleHigh;
    addr = 3'd1;
    while (!done) begin
      #1;
      if (rdData[7]) begin
        busyCnt++;
        if (csN !== expCs) csBad++;
      end else if (csN !== '1) csBad++;
      if (sclk !== prevSclk) begin
        edges++;
        if (edges == 1) firstEdge = k;
        lastEdge = k;
        if (sclk == !fallAct) begin
          got[msb ? (n - 1 - j) : j] = mosi;
          j++;
          if (j < n) miso = msb ? slaveWord[n-1-j] : slaveWord[j];
        end
        prevSclk = sclk;
      end
      if (irq) irqCnt++;
      if (!rdData[7] || k > 2000) done = 1;
      else begin
        @(negedge clk);
        k++;
      end
    end
    check("R3", "busy cycles", 32'(busyCnt), 32'(h * (2 * n + 1)));
    check("R4", "sclk toggles", 32'(edges), 32'(2 * n));
    check("R4", "first edge cycle", 32'(firstEdge), 32'(h + 1));
    check("R4", "last edge cycle", 32'(lastEdge), 32'(2 * n * h + 1));
    check("R5", "mosi frame", 32'(got), 32'(expTx));
    check("R7", "cs mismatches", 32'(csBad), 32'd0);
    check("R11", "irq pulses", 32'(irqCnt), 32'(irqEn));
    hostRead(3'd6, rd);
    check("R6", "data byte 2", 32'(rd), f16 ? 32'(slaveWord[15:8]) : 32'(txWord[15:8]));
    hostRead(3'd7, rd);
    check("R6", "data byte 3", 32'(rd), 32'(slaveWord[7:0]));
    check("R4", "sclk back idle", 32'(sclk), 32'(idleHigh));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1", "csN", 32'(csN), 32'hF);
    check("R1", "sclk", 32'(sclk), 32'd0);
    check("R1", "irq", 32'(irq), 32'd0);
    for (int a = 0; a < 8; a++) begin
      hostRead(3'(a), rd);
      check("R1", "register read", 32'(rd), 32'd0);
    end

    // R2 / R12 register readback while idle
    hostWrite(3'd0, 8'h17);
    hostRead(3'd0, rd);
    check("R2", "control readback", 32'(rd), 32'h17);
    hostWrite(3'd1, 8'hFF);
    hostRead(3'd1, rd);
    check("R12", "status readback", 32'(rd), 32'h0F);
    for (int i = 0; i < 3; i++) begin
      hostWrite(3'(4 + i), 8'(8'h5A + 8'(i * 37)));
      hostRead(3'(4 + i), rd);
      check("R2", "data readback", 32'(rd), 32'(8'(8'h5A + 8'(i * 37))));
    end
    hostWrite(3'd1, 8'h00);

    // sweep of every idle level, sampling edge, order, frame and rate
    for (int ih = 0; ih < 2; ih++)
      for (int fa = 0; fa < 2; fa++)
        for (int ms = 0; ms < 2; ms++)
          for (int fl = 0; fl < 2; fl++)
            for (int rt = 0; rt < 4; rt++) begin
              runXfer(ih[0], fa[0], ms[0], cnt[0], fl[0], 2'(rt), 3'(cnt % NSL),
                      16'hA5C3 ^ 16'(cnt * 16'h1357), 16'h3C96 + 16'(cnt * 16'h0F1D));
              cnt++;
            end

    // R8 manual chip-select
    hostWrite(3'd1, 8'h00);
    hostWrite(3'd0, 8'h82);
    #1 check("R8", "manual cs on", 32'(csN), 32'hB);
    hostWrite(3'd7, 8'h3C);
    #1 check("R8", "manual cs held during transfer", 32'(csN), 32'hB);
    waitIdle();
    hostWrite(3'd0, 8'h02);
    #1 check("R8", "manual cs off", 32'(csN), 32'hF);
    hostWrite(3'd7, 8'h3C);
    #1 check("R8", "no cs during manual-off transfer", 32'(csN), 32'hF);
    waitIdle();

    // R9 index out of range
    hostWrite(3'd0, 8'h25);
    hostWrite(3'd7, 8'h81);
    addr = 3'd1;
    #1 check("R9", "busy during transfer", 32'(rdData[7]), 32'd1);
    check("R9", "no cs for index 5", 32'(csN), 32'hF);
    waitIdle();

    // R10 writes ignored while busy, R12 busy bit
    miso = 1'b0;
    hostWrite(3'd0, 8'h20);
    hostWrite(3'd1, 8'h00);
    hostWrite(3'd4, 8'h11);
    hostWrite(3'd7, 8'h42);
    hostWrite(3'd4, 8'hEE);
    hostWrite(3'd0, 8'hFF);
    hostWrite(3'd1, 8'h0F);
    hostRead(3'd1, rd);
    check("R12", "status while busy", 32'(rd), 32'h80);
    hostWrite(3'd7, 8'h99);
    waitIdle();
    repeat (5) begin
      hostRead(3'd1, rd);
      check("R10", "no second transfer, config kept", 32'(rd), 32'h00);
    end
    hostRead(3'd0, rd);
    check("R10", "control kept", 32'(rd), 32'h20);
    hostRead(3'd4, rd);
    check("R10", "data byte 0 kept", 32'(rd), 32'h11);
    hostRead(3'd7, rd);
    check("R10", "data byte 3 holds received zero", 32'(rd), 32'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule